// File: doc/BRIEF.md
# Swizzled Texel Address Generator

This block turns a texel coordinate into a position inside a swizzled texture layout. Both surface dimensions are powers of two, given as their base-2 logarithms. A square surface interleaves the coordinate bits directly. A rectangular surface is laid out as a run of square swizzled tiles placed one after another in memory. Each tile has the side length of the smaller surface dimension. The block reports the texel index and also a byte offset, which is the index scaled by a texel size of one, two or four bytes.

A request is a single-cycle strobe carrying x, y, the two logarithms and a texel-size code. One clock later the block presents either a valid index and offset, or an error flag. The error flag covers coordinates that fall outside the surface and configurations the block does not support. The datapath is combinational. It feeds a small three-state output stage.

The states are OUT_IDLE, OUT_HIT and OUT_FAULT. On every clock the next state is chosen from the current request. If there is no strobe, the next state is OUT_IDLE. A strobe carrying a bad request leads to OUT_FAULT. Any other strobe leads to OUT_HIT. These transitions are taken from any state, so results can follow one another on consecutive cycles.

Top module: `morton_addr_gen`

## Requirements
- R1: For a square surface (log2 width equal to log2 height), bit i of x appears at index bit 2i and bit i of y appears at index bit 2i+1.
- R2: For a rectangular surface, the tile side s is 2 to the power of the smaller logarithm, with mask m = s-1. The index is (((x | y) & ~m) * s) OR the interleave of (x & m) and (y & m).
- R3: The byte offset is the index times the texel size. Size code 0 means 1 byte, code 1 means 2 bytes, and code 2 means 4 bytes.
- R4: A request strobed on one clock edge produces its result on the next edge. Requests on consecutive cycles each produce their own result on consecutive cycles.
- R5: If x is not below the width or y is not below the height, out_err is raised one cycle later. In that case out_valid stays low.
- R6: A logarithm above 10 or a size code of 3 is reported as an error in the same way as R5.
- R7: When out_valid is low, out_index and out_offset are zero. A cycle without a strobe leaves both flags low on the next cycle.
- R8: A synchronous active-high reset clears both flags and both data outputs.
- R9: out_valid and out_err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_x | input | 11 | Texel column |
| in_y | input | 11 | Texel row |
| in_log2w | input | 4 | Base-2 logarithm of the surface width |
| in_log2h | input | 4 | Base-2 logarithm of the surface height |
| in_size | input | 2 | Texel size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) |
| out_valid | output | 1 | Index and offset are valid |
| out_err | output | 1 | The previous request was rejected |
| out_index | output | 20 | Texel index in the swizzled layout |
| out_offset | output | 22 | Byte offset of the texel |

## Verification
The bench exercises wide and tall rectangles and checks that the tile base uses the smaller side. A design that used the larger side, or that dropped the tile base, would put texels of later tiles on top of the first tile. It also covers degenerate shapes: a 1x1 surface, a 1024x1 strip, and a full 1024x1024 square whose all-ones x or y must yield alternating-bit patterns. A design with a swapped bit lane or a tile base truncated too early would give the wrong value in these cases. Coordinates exactly equal to the width or the height are sent to catch an off-by-one range test. Back-to-back strobes are sent to catch an output stage that drops or repeats a result.

// File: rtl/morton_pkg.sv
package morton_pkg;
    localparam int unsigned LOG2_MAX_DEF = 10;

    typedef enum logic [1:0] {
        TEX_1B  = 2'd0,
        TEX_2B  = 2'd1,
        TEX_4B  = 2'd2,
        TEX_BAD = 2'd3
    } tex_size_e;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_FAULT = 2'd2
    } out_state_e;
endpackage

// File: rtl/morton_bounds.sv
module morton_bounds #(
    parameter int unsigned LOG2_MAX = 10,
    localparam int unsigned COORD_W = LOG2_MAX + 1,
    localparam int unsigned LOG2_W  = $clog2(LOG2_MAX + 1)
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [LOG2_W-1:0]  log2w,
    input  logic [LOG2_W-1:0]  log2h,
    input  logic [1:0]         size_code,
    output logic               fault
);
    import morton_pkg::*;

    logic dim_bad, x_out, y_out, size_bad;

    always_comb begin
        dim_bad  = (32'(log2w) > LOG2_MAX) || (32'(log2h) > LOG2_MAX);
        x_out    = (x >> log2w) != '0;
        y_out    = (y >> log2h) != '0;
        size_bad = (tex_size_e'(size_code) == TEX_BAD);
        fault    = dim_bad | x_out | y_out | size_bad;
    end
endmodule

// File: rtl/morton_interleave.sv
module morton_interleave #(
    parameter int unsigned LOG2_MAX = 10,
    localparam int unsigned COORD_W = LOG2_MAX + 1,
    localparam int unsigned LOG2_W  = $clog2(LOG2_MAX + 1),
    localparam int unsigned IDX_W   = 2 * LOG2_MAX
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [LOG2_W-1:0]  side_log2,
    output logic [IDX_W-1:0]   low_bits
);
    logic [COORD_W-1:0] tile_mask;
    logic [COORD_W-1:0] xm, ym;

    always_comb begin
        tile_mask = (COORD_W'(1) << side_log2) - COORD_W'(1);
        xm = x & tile_mask;
        ym = y & tile_mask;
    end

    for (genvar i = 0; i < LOG2_MAX; i++) begin : g_lane
        assign low_bits[2*i]   = xm[i];
        assign low_bits[2*i+1] = ym[i];
    end
endmodule

// File: rtl/morton_tile_base.sv
module morton_tile_base #(
    parameter int unsigned LOG2_MAX = 10,
    localparam int unsigned COORD_W = LOG2_MAX + 1,
    localparam int unsigned LOG2_W  = $clog2(LOG2_MAX + 1),
    localparam int unsigned IDX_W   = 2 * LOG2_MAX
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [LOG2_W-1:0]  side_log2,
    output logic [IDX_W-1:0]   base
);
    logic [COORD_W-1:0] tile_num;
    logic [LOG2_W:0]    tile_shift;

    always_comb begin
        tile_num   = (x | y) >> side_log2;
        tile_shift = {side_log2, 1'b0};
        base       = IDX_W'(tile_num) << tile_shift;
    end
endmodule

// File: rtl/morton_addr_gen.sv
module morton_addr_gen #(
    parameter int unsigned LOG2_MAX = morton_pkg::LOG2_MAX_DEF,
    localparam int unsigned COORD_W = LOG2_MAX + 1,
    localparam int unsigned LOG2_W  = $clog2(LOG2_MAX + 1),
    localparam int unsigned IDX_W   = 2 * LOG2_MAX,
    localparam int unsigned OFS_W   = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [LOG2_W-1:0]  in_log2w,
    input  logic [LOG2_W-1:0]  in_log2h,
    input  logic [1:0]         in_size,
    output logic               out_valid,
    output logic               out_err,
    output logic [IDX_W-1:0]   out_index,
    output logic [OFS_W-1:0]   out_offset
);
    import morton_pkg::*;

    out_state_e         state_q, state_d;
    logic [LOG2_W-1:0]  side_log2;
    logic               fault;
    logic [IDX_W-1:0]   low_bits, base, idx_c, idx_q;
    logic [OFS_W-1:0]   ofs_c, ofs_q;

    assign side_log2 = (in_log2w < in_log2h) ? in_log2w : in_log2h;

    morton_bounds #(.LOG2_MAX(LOG2_MAX)) bounds_i (
        .x(in_x), .y(in_y), .log2w(in_log2w), .log2h(in_log2h),
        .size_code(in_size), .fault(fault)
    );

    morton_interleave #(.LOG2_MAX(LOG2_MAX)) ilv_i (
        .x(in_x), .y(in_y), .side_log2(side_log2), .low_bits(low_bits)
    );

    morton_tile_base #(.LOG2_MAX(LOG2_MAX)) base_i (
        .x(in_x), .y(in_y), .side_log2(side_log2), .base(base)
    );

    always_comb begin
        idx_c = base | low_bits;
        unique case (tex_size_e'(in_size))
            TEX_1B:  ofs_c = OFS_W'(idx_c);
            TEX_2B:  ofs_c = OFS_W'({idx_c, 1'b0});
            TEX_4B:  ofs_c = {idx_c, 2'b00};
            default: ofs_c = '0;
        endcase
    end

    // next-state selection
    always_comb begin
        if (!in_valid)  state_d = OUT_IDLE;
        else if (fault) state_d = OUT_FAULT;
        else            state_d = OUT_HIT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_IDLE;
        else     state_q <= state_d;
    end

    // data register, cleared unless a result is produced
    always_ff @(posedge clk) begin
        if (rst || state_d != OUT_HIT) begin
            idx_q <= '0;
            ofs_q <= '0;
        end else begin
            idx_q <= idx_c;
            ofs_q <= ofs_c;
        end
    end

    // outputs
    always_comb begin
        out_valid  = 1'b0;
        out_err    = 1'b0;
        out_index  = idx_q;
        out_offset = ofs_q;
        unique case (state_q)
            OUT_IDLE:  ;
            OUT_HIT:   out_valid = 1'b1;
            OUT_FAULT: out_err   = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/morton_addr_gen_chk.sv
module morton_addr_gen_chk #(
    parameter int unsigned LOG2_MAX = 10,
    localparam int unsigned COORD_W = LOG2_MAX + 1,
    localparam int unsigned LOG2_W  = $clog2(LOG2_MAX + 1),
    localparam int unsigned IDX_W   = 2 * LOG2_MAX,
    localparam int unsigned OFS_W   = IDX_W + 2
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [LOG2_W-1:0]  in_log2w,
    input logic [LOG2_W-1:0]  in_log2h,
    input logic [1:0]         in_size,
    input logic               out_valid,
    input logic               out_err,
    input logic [IDX_W-1:0]   out_index,
    input logic [OFS_W-1:0]   out_offset
);
    // R9
    excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, out_err}));

    // R4
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid || out_err) |-> $past(in_valid));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_err));

    // R7
    zero_when_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_index == '0 && out_offset == '0));

    // R3
    quad_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_size) == 2'd2) |-> (out_offset == {out_index, 2'b00}));

    // R2
    index_in_surface_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_index >> ({1'b0, $past(in_log2w)} + {1'b0, $past(in_log2h)})) == '0));
endmodule

bind morton_addr_gen morton_addr_gen_chk #(.LOG2_MAX(LOG2_MAX)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_log2w(in_log2w),
    .in_log2h(in_log2h), .in_size(in_size), .out_valid(out_valid),
    .out_err(out_err), .out_index(out_index), .out_offset(out_offset)
);

// File: tb/morton_addr_gen_tb_top.sv
module morton_addr_gen_tb_top;
    localparam int unsigned LOG2_MAX = 10;
    localparam int unsigned COORD_W  = LOG2_MAX + 1;
    localparam int unsigned LOG2_W   = $clog2(LOG2_MAX + 1);
    localparam int unsigned IDX_W    = 2 * LOG2_MAX;
    localparam int unsigned OFS_W    = IDX_W + 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [COORD_W-1:0] in_x = '0;
    logic [COORD_W-1:0] in_y = '0;
    logic [LOG2_W-1:0]  in_log2w = '0;
    logic [LOG2_W-1:0]  in_log2h = '0;
    logic [1:0]         in_size = '0;
    logic               out_valid, out_err;
    logic [IDX_W-1:0]   out_index;
    logic [OFS_W-1:0]   out_offset;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    morton_addr_gen #(.LOG2_MAX(LOG2_MAX)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_log2w(in_log2w), .in_log2h(in_log2h), .in_size(in_size),
        .out_valid(out_valid), .out_err(out_err),
        .out_index(out_index), .out_offset(out_offset)
    );

    function automatic int unsigned ref_index(int unsigned x, int unsigned y,
                                              int unsigned lw, int unsigned lh);
        int unsigned sl = (lw < lh) ? lw : lh;
        int unsigned r = 0;
        for (int i = 0; i < 16; i++) begin
            if (i < sl) begin
                r |= ((x >> i) & 1) << (2 * i);
                r |= ((y >> i) & 1) << (2 * i + 1);
            end
        end
        r |= ((x | y) >> sl) << (2 * sl);
        return r;
    endfunction

    task automatic check(string req, longint unsigned act, longint unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(int unsigned x, int unsigned y, int unsigned lw,
                         int unsigned lh, int unsigned sz);
        in_x = COORD_W'(x); in_y = COORD_W'(y);
        in_log2w = LOG2_W'(lw); in_log2h = LOG2_W'(lh);
        in_size = 2'(sz); in_valid = 1'b1;
    endtask

    // one request, result sampled on the following falling edge
    task automatic send(int unsigned x, int unsigned y, int unsigned lw,
                        int unsigned lh, int unsigned sz);
        @(negedge clk);
        drive(x, y, lw, lh, sz);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_hit(string req, int unsigned x, int unsigned y,
                              int unsigned lw, int unsigned lh, int unsigned sz);
        int unsigned e = ref_index(x, y, lw, lh);
        send(x, y, lw, lh, sz);
        check({req, " valid"}, out_valid, 1);
        check({req, " err"}, out_err, 0);
        check({req, " index"}, out_index, e);
        check({req, " offset"}, out_offset, longint'(e) << sz);
    endtask

    task automatic expect_err(string req, int unsigned x, int unsigned y,
                              int unsigned lw, int unsigned lh, int unsigned sz);
        send(x, y, lw, lh, sz);
        check({req, " err"}, out_err, 1);
        check({req, " valid"}, out_valid, 0);
        check({req, " index"}, out_index, 0);
        check({req, " offset"}, out_offset, 0);
    endtask

    task automatic t_reset();
        // R8
        check("R8 valid", out_valid, 0);
        check("R8 err", out_err, 0);
        check("R8 index", out_index, 0);
        check("R8 offset", out_offset, 0);
    endtask

    task automatic t_square();
        expect_hit("R1 4x4", 3, 1, 2, 2, 0);
        check("R1 4x4 literal", out_index, 7);
        expect_hit("R1 full x", 1023, 0, 10, 10, 0);
        check("R1 full x literal", out_index, 20'h55555);
        expect_hit("R1 full y", 0, 1023, 10, 10, 0);
        check("R1 full y literal", out_index, 20'hAAAAA);
        expect_hit("R1 1x1", 0, 0, 0, 0, 0);
    endtask

    task automatic t_rect();
        expect_hit("R2 wide", 5, 1, 3, 1, 0);
        check("R2 wide literal", out_index, 11);
        expect_hit("R2 tall", 1, 6, 1, 3, 0);
        check("R2 tall literal", out_index, 13);
        expect_hit("R2 strip", 1023, 0, 10, 0, 0);
        check("R2 strip literal", out_index, 1023);
        expect_hit("R2 last texel", 1023, 511, 10, 9, 0);
        check("R2 last texel literal", out_index, 20'h7FFFF);
    endtask

    task automatic t_size();
        expect_hit("R3 1B", 9, 5, 4, 4, 0);
        expect_hit("R3 2B", 9, 5, 4, 4, 1);
        check("R3 2B literal", out_offset, longint'(ref_index(9, 5, 4, 4)) * 2);
        expect_hit("R3 4B", 1023, 1023, 10, 10, 2);
        check("R3 4B literal", out_offset, 22'h3FFFFC);
    endtask

    task automatic t_errors();
        expect_err("R5 x==w", 16, 0, 4, 5, 0);
        expect_err("R5 y==h", 0, 32, 4, 5, 0);
        expect_err("R6 size3", 1, 1, 4, 4, 3);
        expect_err("R6 log2w", 0, 0, 11, 2, 0);
    endtask

    task automatic t_stream();
        // R4 back-to-back requests
        @(negedge clk);
        drive(2, 3, 2, 2, 0);
        @(negedge clk);
        check("R4 first valid", out_valid, 1);
        check("R4 first index", out_index, ref_index(2, 3, 2, 2));
        drive(4, 0, 3, 1, 1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 second valid", out_valid, 1);
        check("R4 second index", out_index, ref_index(4, 0, 3, 1));
        // R7 idle cycle after stream
        @(negedge clk);
        check("R7 idle valid", out_valid, 0);
        check("R7 idle err", out_err, 0);
        check("R7 idle index", out_index, 0);
        // error followed immediately by a hit
        @(negedge clk);
        drive(8, 0, 3, 3, 0);
        @(negedge clk);
        check("R5 err in stream", out_err, 1);
        drive(7, 7, 3, 3, 0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 hit after err valid", out_valid, 1);
        check("R9 hit after err flag", out_err, 0);
        check("R4 hit after err index", out_index, 63);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_square();
        t_rect();
        t_size();
        t_errors();
        t_stream();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule